// File: doc/BRIEF.md
# Absolute-to-Physical Address Mapper

This block turns an absolute address into a physical address for the periods when virtual translation is switched off. Three status inputs pick the mapping. The translation-enable input takes priority: a request made while it is set belongs to the translating path and is not mapped here. When translation is off, the wide input chooses a 64-bit absolute address. That address is cut down to its low N bits and then sign-extended from bit N-1. When both translation and wide are off, a 32-bit absolute address is mapped. On the newer architecture version that address is first sorted into memory, I/O or firmware space. On the older version it is simply zero-extended.

Each request is a single-cycle strobe carrying the address and the status bits. One clock later the block presents the registered 64-bit physical address with a one-cycle valid strobe. With every result it grants read, write and execute permission. Between results the address output keeps its last value. The parameter N (`PA_BITS`, default 40) sets the implemented physical width. Elaboration stops with an error if N is above 54.

Top module: `abs_phys_mapper`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `out_valid`=0, `out_paddr`=0 and `out_perm`=0.
- R2: A request accepted at an edge (`in_valid`=1 and `xlat_en`=0) sets `out_valid` for exactly the following cycle. No other request sets it.
- R3: A request with `xlat_en`=1 is ignored: it raises no `out_valid` and leaves `out_paddr` unchanged, whatever the other inputs are.
- R4: With `wide_en`=1, `out_paddr` is `in_addr[N-1:0]` sign-extended from bit N-1 to 64 bits. `arch_new` does not affect this.
- R5: With `wide_en`=0 and `arch_new`=1, when `in_addr[31:28]` is not 0xF (memory space), `out_paddr` is `in_addr[31:0]` zero-extended. `in_addr[63:32]` is ignored.
- R6: With `wide_en`=0 and `arch_new`=1, when `in_addr[31:28]` is 0xF and `in_addr[27:24]` is non-zero (I/O space), `out_paddr` is `in_addr[31:0]` sign-extended from bit 31.
- R7: With `wide_en`=0 and `arch_new`=1, when `in_addr[31:24]` is 0xF0 (firmware space), `out_paddr` is `in_addr[31:0]` zero-extended, and then every bit from N-4 through 63 is forced to one.
- R8: With `wide_en`=0 and `arch_new`=0, `out_paddr` is `in_addr[31:0]` zero-extended for every address, including those with a top nibble of 0xF.
- R9: `out_perm` is 3'b111 in each cycle `out_valid` is 1 (bit 2 read, bit 1 write, bit 0 execute) and 3'b000 otherwise.
- R10: In a cycle after an edge with no accepted request, `out_paddr` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_addr | input | 64 | Absolute address of the request |
| xlat_en | input | 1 | Data translation enabled; the request is not mapped here |
| wide_en | input | 1 | Selects the 64-bit absolute mapping |
| arch_new | input | 1 | Newer architecture version; enables the 32-bit space split |
| out_valid | output | 1 | Result strobe, one cycle after an accepted request |
| out_paddr | output | 64 | Registered physical address |
| out_perm | output | 3 | Granted permissions {read, write, execute} |

## Verification
The bench targets the region boundaries in the 32-bit mapping: 0xEFFFFFFF against 0xF0000000, 0xF0FFFFFF against 0xF1000000, and 0xFFFFFFFF. A decoder that tested the wrong nibble or used the wrong comparison would zero-extend an I/O address or sign-extend a firmware address. Wide addresses are driven with bit N-1 both set and clear, and with garbage above bit N-1, so that a wrong sign bit or a missing truncation shows up in the upper word. The same 0xF-prefixed addresses are sent with `arch_new` cleared, and translated requests are mixed in with garbage fields. A design that ignored the version flag, or that let a translated request through, would produce a wrong address or a stray valid strobe.

// File: rtl/absmap_pkg.sv
// Package: absmap_pkg
// Shared types for the absolute-to-physical mapper.
// Assumes a 64-bit address datapath and a 32-bit narrow address.
package absmap_pkg;
    localparam int unsigned ADDR_W   = 64;
    localparam int unsigned NARROW_W = 32;
    localparam int unsigned PERM_W   = 3;

    // Mapping path chosen from the status bits
    typedef enum logic [1:0] {
        PATH_NONE   = 2'd0,
        PATH_WIDE   = 2'd1,
        PATH_NARROW = 2'd2,
        PATH_LEGACY = 2'd3
    } map_path_t;

    // Space of a narrow address on the newer architecture
    typedef enum logic [1:0] {
        SPACE_MEM = 2'd0,
        SPACE_IO  = 2'd1,
        SPACE_FW  = 2'd2
    } narrow_space_t;

    // Final mapping kind applied by the extender
    typedef enum logic [2:0] {
        KIND_NONE   = 3'd0,
        KIND_WIDE   = 3'd1,
        KIND_ZEXT   = 3'd2,
        KIND_SEXT32 = 3'd3,
        KIND_FW     = 3'd4
    } map_kind_t;

    localparam logic [PERM_W-1:0] PERM_ALL  = 3'b111;
    localparam logic [PERM_W-1:0] PERM_NONE = 3'b000;
endpackage

// File: rtl/absmap_path_sel.sv
// Module: absmap_path_sel
// Chooses the mapping path from the status bits. Translation takes
// priority, then the wide bit, then the architecture version.
// Assumes all inputs are stable around the sampling edge.
module absmap_path_sel
    import absmap_pkg::*;
(
    input  logic      in_valid,
    input  logic      xlat_en,
    input  logic      wide_en,
    input  logic      arch_new,
    output logic      accept,
    output map_path_t path
);
    // Priority selection of the path and acceptance of the request
    always_comb begin
        accept = in_valid && !xlat_en;
        if (!accept)      path = PATH_NONE;
        else if (wide_en) path = PATH_WIDE;
        else if (arch_new) path = PATH_NARROW;
        else              path = PATH_LEGACY;
    end
endmodule

// File: rtl/absmap_space_decode.sv
// Module: absmap_space_decode
// Sorts a narrow address into memory, I/O or firmware space from its
// top two nibbles. Only bits [31:24] of the address are examined.
module absmap_space_decode
    import absmap_pkg::*;
(
    input  logic [7:0]    top_byte,
    output narrow_space_t space
);
    localparam logic [3:0] HIGH_NIB = 4'hF;

    // Region decode from the two nibbles
    always_comb begin
        if (top_byte[7:4] != HIGH_NIB)  space = SPACE_MEM;
        else if (top_byte[3:0] != 4'h0) space = SPACE_IO;
        else                            space = SPACE_FW;
    end
endmodule

// File: rtl/absmap_extend.sv
// Module: absmap_extend
// Produces the 64-bit physical address for a mapping kind.
// Assumes 4 < PA_BITS <= 54 (checked at the top).
module absmap_extend
    import absmap_pkg::*;
#(
    parameter int unsigned PA_BITS = 40
) (
    input  logic [ADDR_W-1:0] addr,
    input  map_kind_t         kind,
    output logic [ADDR_W-1:0] paddr
);
    localparam int unsigned WIDE_PAD = ADDR_W - PA_BITS;
    localparam int unsigned FW_LOW   = PA_BITS - 4;
    localparam logic [ADDR_W-1:0] FW_ONES = ~((64'd1 << FW_LOW) - 64'd1);

    logic [ADDR_W-1:0] wide_val;
    logic [ADDR_W-1:0] zext_val;
    logic [ADDR_W-1:0] sext_val;

    // Candidate results for each extension style
    always_comb begin
        wide_val = {{WIDE_PAD{addr[PA_BITS-1]}}, addr[PA_BITS-1:0]};
        zext_val = {{(ADDR_W-NARROW_W){1'b0}}, addr[NARROW_W-1:0]};
        sext_val = {{(ADDR_W-NARROW_W){addr[NARROW_W-1]}}, addr[NARROW_W-1:0]};
    end

    // Select the candidate for the requested kind
    always_comb begin
        unique case (kind)
            KIND_WIDE:   paddr = wide_val;
            KIND_ZEXT:   paddr = zext_val;
            KIND_SEXT32: paddr = sext_val;
            KIND_FW:     paddr = zext_val | FW_ONES;
            default:     paddr = '0;
        endcase
    end
endmodule

// File: rtl/absmap_out_reg.sv
// Module: absmap_out_reg
// Output register stage: captures an accepted result, holds the
// address otherwise, and grants full permission with each strobe.
module absmap_out_reg
    import absmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] paddr_d,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_paddr,
    output logic [PERM_W-1:0] out_perm
);
    // Register result, strobe and permission with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_paddr <= '0;
            out_perm  <= PERM_NONE;
        end else begin
            out_valid <= accept;
            out_perm  <= accept ? PERM_ALL : PERM_NONE;
            if (accept) out_paddr <= paddr_d;
        end
    end
endmodule

// File: rtl/abs_phys_mapper.sv
// Module: abs_phys_mapper
// Maps absolute addresses to physical addresses while virtual
// translation is off. One cycle of latency from request to result.
// Assumes PA_BITS in the range 5..54.
module abs_phys_mapper
    import absmap_pkg::*;
#(
    parameter int unsigned PA_BITS = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [63:0]          in_addr,
    input  logic                 xlat_en,
    input  logic                 wide_en,
    input  logic                 arch_new,
    output logic                 out_valid,
    output logic [63:0]          out_paddr,
    output logic [2:0]           out_perm
);
    generate
        if (PA_BITS > 54 || PA_BITS < 5) begin : g_bad_width
            $error("abs_phys_mapper: PA_BITS must lie in 5..54");
        end
    endgenerate

    logic          accept;
    map_path_t     path;
    narrow_space_t space;
    map_kind_t     kind;
    logic [ADDR_W-1:0] paddr_d;

    absmap_path_sel u_path (
        .in_valid (in_valid),
        .xlat_en  (xlat_en),
        .wide_en  (wide_en),
        .arch_new (arch_new),
        .accept   (accept),
        .path     (path)
    );

    absmap_space_decode u_space (
        .top_byte (in_addr[31:24]),
        .space    (space)
    );

    // Combine path and space into the extension kind
    always_comb begin
        unique case (path)
            PATH_WIDE:   kind = KIND_WIDE;
            PATH_LEGACY: kind = KIND_ZEXT;
            PATH_NARROW: begin
                unique case (space)
                    SPACE_IO: kind = KIND_SEXT32;
                    SPACE_FW: kind = KIND_FW;
                    default:  kind = KIND_ZEXT;
                endcase
            end
            default:     kind = KIND_NONE;
        endcase
    end

    absmap_extend #(.PA_BITS(PA_BITS)) u_ext (
        .addr  (in_addr),
        .kind  (kind),
        .paddr (paddr_d)
    );

    absmap_out_reg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .paddr_d   (paddr_d),
        .out_valid (out_valid),
        .out_paddr (out_paddr),
        .out_perm  (out_perm)
    );
endmodule

// File: rtl/absmap_checker.sv
// Module: absmap_checker
// Property checks on the mapper's ports, bound to every instance.
module absmap_checker #(
    parameter int unsigned PA_BITS = 40
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] in_addr,
    input logic        xlat_en,
    input logic        wide_en,
    input logic        arch_new,
    input logic        out_valid,
    input logic [63:0] out_paddr,
    input logic [2:0]  out_perm
);
    logic acc;
    logic narrow_new;
    assign acc        = in_valid && !xlat_en;
    assign narrow_new = acc && !wide_en && arch_new;

    // R1: reset clears the strobe
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_paddr == 64'd0 && out_perm == 3'b000));

    // R2: strobe follows an accepted request by one cycle
    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);

    // R3: translated or absent requests raise no strobe
    assert_no_stray_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !out_valid);

    // R4: wide result sign-extended from bit N-1
    assert_wide_sext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wide_en) |=>
        (out_paddr[PA_BITS-1:0] == $past(in_addr[PA_BITS-1:0]) &&
         out_paddr[63:PA_BITS] == {(64-PA_BITS){$past(in_addr[PA_BITS-1])}}));

    // R5: memory space zero-extended
    assert_mem_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow_new && in_addr[31:28] != 4'hF) |=>
        (out_paddr == {32'd0, $past(in_addr[31:0])}));

    // R6: I/O space upper word all ones
    assert_io_sext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow_new && in_addr[31:28] == 4'hF && in_addr[27:24] != 4'h0) |=>
        (out_paddr == {32'hFFFF_FFFF, $past(in_addr[31:0])}));

    // R7: firmware space forced ones from N-4 upward
    assert_fw_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow_new && in_addr[31:24] == 8'hF0) |=>
        (&out_paddr[63:PA_BITS-4] && out_paddr[31:0] == $past(in_addr[31:0])));

    // R8: older version always zero-extends
    assert_legacy_zext_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !wide_en && !arch_new) |=>
        (out_paddr == {32'd0, $past(in_addr[31:0])}));

    // R9: permissions tied to the strobe
    assert_perm_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_perm == (out_valid ? 3'b111 : 3'b000));

    // R10: address held when nothing is accepted
    assert_hold_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(out_paddr));
endmodule

bind abs_phys_mapper absmap_checker #(.PA_BITS(PA_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .xlat_en   (xlat_en),
    .wide_en   (wide_en),
    .arch_new  (arch_new),
    .out_valid (out_valid),
    .out_paddr (out_paddr),
    .out_perm  (out_perm)
);

// File: tb/abs_phys_mapper_bench.sv
module abs_phys_mapper_bench;
    localparam int N = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic        xlat_en = 1'b0;
    logic        wide_en = 1'b0;
    logic        arch_new = 1'b0;
    logic        out_valid;
    logic [63:0] out_paddr;
    logic [2:0]  out_perm;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Expected values, one entry per cycle
    bit          q_v[$];
    logic [63:0] q_a[$];
    logic [2:0]  q_p[$];
    string       q_t[$];
    logic [63:0] model_addr = '0;

    always #5 clk = ~clk;

    abs_phys_mapper #(.PA_BITS(N)) u_abs_phys_mapper (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .xlat_en(xlat_en), .wide_en(wide_en), .arch_new(arch_new),
        .out_valid(out_valid), .out_paddr(out_paddr), .out_perm(out_perm)
    );

    // Reference mapping written from the requirements
    function automatic logic [63:0] ref_map(input logic [63:0] a, input logic w,
                                            input logic ar, output string tag);
        longint unsigned low_mask;
        logic [63:0] lo32;
        lo32 = {32'd0, a[31:0]};
        if (w) begin
            tag = "R4";
            low_mask = (64'd1 << N) - 1;
            ref_map = a & low_mask;
            if (a[N-1]) ref_map = ref_map | ~low_mask;
        end else if (!ar) begin
            tag = "R8";
            ref_map = lo32;
        end else if (a[31:28] != 4'hF) begin
            tag = "R5";
            ref_map = lo32;
        end else if (a[27:24] != 4'h0) begin
            tag = "R6";
            ref_map = lo32 | 64'hFFFF_FFFF_0000_0000;
        end else begin
            tag = "R7";
            ref_map = lo32 | ~((64'd1 << (N - 4)) - 1);
        end
    endfunction

    // One cycle: compare the pending expectation, then drive new inputs
    task automatic step(input logic rn, input logic v, input logic [63:0] a,
                        input logic x, input logic w, input logic ar);
        string tg;
        logic [63:0] ea;
        @(negedge clk);
        if (q_v.size() > 0) begin
            bit ev = q_v.pop_front();
            logic [63:0] eaddr = q_a.pop_front();
            logic [2:0] ep = q_p.pop_front();
            string et = q_t.pop_front();
            checks++;
            if (out_valid !== ev || out_paddr !== eaddr || out_perm !== ep) begin
                errors++;
                $display("FAIL %s (R2 strobe, R9 perm): got v=%0b a=%h p=%b expected v=%0b a=%h p=%b",
                         et, out_valid, out_paddr, out_perm, ev, eaddr, ep);
            end
        end
        rst_n = rn; in_valid = v; in_addr = a; xlat_en = x; wide_en = w; arch_new = ar;
        if (!rn) begin
            model_addr = '0;
            q_v.push_back(1'b0); q_a.push_back('0); q_p.push_back(3'b000); q_t.push_back("R1");
        end else if (v && !x) begin
            ea = ref_map(a, w, ar, tg);
            model_addr = ea;
            q_v.push_back(1'b1); q_a.push_back(ea); q_p.push_back(3'b111); q_t.push_back(tg);
        end else begin
            q_v.push_back(1'b0); q_a.push_back(model_addr); q_p.push_back(3'b000);
            q_t.push_back((v && x) ? "R3" : "R10");
        end
    endtask

    // Watchdog
    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset
        step(0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 1);
        step(0, 0, 64'h0, 0, 0, 0);
        step(0, 1, 64'h1234, 0, 0, 1);
        // R4: wide, bit N-1 set and clear, garbage above
        step(1, 1, 64'h0000_0080_1234_5678, 0, 1, 1);
        step(1, 1, 64'h1234_0012_3456_789A, 0, 1, 0);
        step(1, 1, 64'hABCD_FF80_0000_0001, 0, 1, 0);
        // R10: idle hold
        step(1, 0, 64'hDEAD_BEEF_DEAD_BEEF, 0, 0, 1);
        step(1, 0, 64'h0, 0, 1, 0);
        // R5: memory space boundaries
        step(1, 1, 64'hDEAD_BEEF_7000_0000, 0, 0, 1);
        step(1, 1, 64'hFFFF_FFFF_EFFF_FFFF, 0, 0, 1);
        step(1, 1, 64'h0, 0, 0, 1);
        // R6: I/O space boundaries
        step(1, 1, 64'h0000_0000_F100_0000, 0, 0, 1);
        step(1, 1, 64'h5555_5555_FFFF_FFFF, 0, 0, 1);
        // R7: firmware space boundaries
        step(1, 1, 64'h0000_0000_F0AB_CDEF, 0, 0, 1);
        step(1, 1, 64'h1111_1111_F000_0000, 0, 0, 1);
        step(1, 1, 64'h0000_0000_F0FF_FFFF, 0, 0, 1);
        // R8: older version, same prefixes
        step(1, 1, 64'hAAAA_AAAA_F000_1234, 0, 0, 0);
        step(1, 1, 64'h0000_0000_FFFF_FFFF, 0, 0, 0);
        // R3: translated requests ignored
        step(1, 1, 64'hFFFF_FFFF_F100_0000, 1, 0, 1);
        step(1, 1, 64'h0000_0080_0000_0000, 1, 1, 0);
        step(1, 1, 64'h0000_0000_0000_0042, 0, 0, 1);
        step(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 1);
        // R1: reset mid-run
        step(0, 1, 64'h0000_0000_1234_5678, 0, 0, 1);
        step(1, 0, 64'h0, 0, 0, 0);
        // Mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [63:0] a;
            logic [2:0] pick;
            a = {$urandom(), $urandom()};
            pick = 3'($urandom_range(0, 7));
            if (pick == 3'd0) a[31:24] = 8'hF0;
            else if (pick == 3'd1) a[31:28] = 4'hF;
            step(1, 1'($urandom_range(0, 3) != 0), a, 1'($urandom_range(0, 4) == 0),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0));
        end
        step(1, 0, 64'h0, 0, 0, 0);
        step(1, 0, 64'h0, 0, 0, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule